// File: doc/BRIEF.md
# Interrupt Source Latch and Pin Driver

This block gathers the interrupt events of a motion-sensing front end and turns them into readable source and status bytes and one physical interrupt line. It has two event inputs. A new-sample strobe reports fresh conversion data. A wake-up strobe reports motion and carries six axis/direction flags. A host interface outside the block decodes register reads into two strobes. One strobe marks a read of the acceleration output bytes. The other marks a read of the release register, which clears everything the block has latched.

The interrupt line has an enable, a polarity select and a mode select. In latched mode the line stays asserted from the first event until a release read. In pulse mode each event produces one pulse of `PULSE_CYCLES` system clocks. With the default of 4000 cycles at 100 MHz the pulse is 40 µs. A wake-up pulse is one-shot: after it fires, further wake-up events pulse nothing until a release read re-arms it. Data-ready pulses are not limited in this way.

Top module: `irq_latch_ctrl`

## Requirements
- R1: After reset, `src1`, `src2` and `status` read 0x00 and `irq_pin` sits at its inactive level, which is the inverse of `pin_pol`.
- R2: `src1` bit 4 (data ready) is set at the clock edge that samples `sample_stb` while `drdy_en` is 1. A sample with `drdy_en` at 0 leaves it 0. Bits 7, 6, 5, 3, 2 and 0 of `src1` always read 0.
- R3: The data-ready bit clears at the edge that samples `data_rd` or `release_rd`. If a qualifying sample arrives in the same cycle, the bit stays set.
- R4: A `wake_stb` sets `src1` bit 1 and ORs `wake_dir` into `src2` bits 5..0. These bits are X-, X+, Y-, Y+, Z-, Z+ from bit 5 down to bit 0, and `src2` bits 7..6 read 0. These bits survive `data_rd` and clear only on `release_rd`. A wake in the same cycle as a release leaves them set with the new flags.
- R5: `status` bit 4 sets on any latched event (qualifying sample or wake) and clears on `data_rd` or `release_rd`, with the event winning a tie. All other `status` bits read 0.
- R6: With `pin_en` at 0 the pin holds its inactive level. With `pin_en` at 1, `pin_pol` = 1 makes the active level high and `pin_pol` = 0 makes it low.
- R7: In latched mode (`pin_pulse` = 0) the pin goes active one clock after the edge that latches an event. It stays active until one clock after the edge that samples `release_rd`. `data_rd` does not release it.
- R8: In pulse mode (`pin_pulse` = 1) an event makes the pin active for exactly `PULSE_CYCLES` clocks, starting one clock after the event's edge. An event during a pulse restarts the full width.
- R9: In pulse mode a wake-up event pulses only while armed. The block starts armed, a wake-up disarms it, and only a release read re-arms it. Data-ready pulses occur whether or not the block is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_stb | input | 1 | One-cycle strobe: new acceleration sample available |
| wake_stb | input | 1 | One-cycle strobe: motion event detected |
| wake_dir | input | 6 | Axis/direction flags of the motion event, X- to Z+ from bit 5 down to bit 0 |
| data_rd | input | 1 | One-cycle strobe: acceleration output bytes were read |
| release_rd | input | 1 | One-cycle strobe: release register was read |
| drdy_en | input | 1 | Report new samples as interrupts |
| pin_en | input | 1 | Drive the interrupt line to its active level when events occur |
| pin_pol | input | 1 | 1 = active high, 0 = active low |
| pin_pulse | input | 1 | 1 = pulse mode, 0 = latched mode |
| src1 | output | 8 | Source byte 1: data-ready in bit 4, wake-up in bit 1 |
| src2 | output | 8 | Source byte 2: latched motion directions in bits 5..0 |
| status | output | 8 | Status byte: combined interrupt flag in bit 4 |
| irq_pin | output | 1 | Physical interrupt line |

## Verification
The hardest state to reach from the ports is a disarmed wake-up in pulse mode. The stimulus must fire one wake pulse and then send further wake events without a release read between them, and it must show that the line stays quiet while data-ready pulses still come through. The bench then issues a release read and shows that the next wake event pulses again. Pulse restarts are measured by counting active cycles across a second event that lands in the middle of a pulse. The direction bits are swept over all 64 flag patterns, and the pin is checked over every combination of enable, polarity and mode.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
  localparam int DIR_W          = 6;
  localparam int BYTE_W         = 8;
  localparam int SRC1_DRDY_BIT  = 4;
  localparam int SRC1_WAKE_BIT  = 1;
  localparam int STAT_INT_BIT   = 4;
  typedef logic [DIR_W-1:0]  dir_t;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/irq_src_latch.sv
module irq_src_latch
  import irq_latch_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  drdy_evt,
  input  logic  wake_evt,
  input  dir_t  wake_dir,
  input  logic  data_rd,
  input  logic  release_rd,
  output byte_t src1,
  output byte_t src2,
  output byte_t status
);
  logic drdy_q, wake_q, int_q;
  dir_t dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drdy_q <= 1'b0;
      wake_q <= 1'b0;
      int_q  <= 1'b0;
    end else begin
      if (drdy_evt)                   drdy_q <= 1'b1;
      else if (data_rd || release_rd) drdy_q <= 1'b0;
      if (wake_evt)                   wake_q <= 1'b1;
      else if (release_rd)            wake_q <= 1'b0;
      if (drdy_evt || wake_evt)       int_q  <= 1'b1;
      else if (data_rd || release_rd) int_q  <= 1'b0;
    end
  end

  // one latch cell per direction flag
  for (genvar i = 0; i < DIR_W; i++) begin : g_dir
    always_ff @(posedge clk) begin
      if (rst)                          dir_q[i] <= 1'b0;
      else if (wake_evt && wake_dir[i]) dir_q[i] <= 1'b1;
      else if (release_rd)              dir_q[i] <= 1'b0;
    end
  end

  always_comb begin
    src1 = '0;
    src1[SRC1_DRDY_BIT] = drdy_q;
    src1[SRC1_WAKE_BIT] = wake_q;
    src2 = '0;
    src2[DIR_W-1:0] = dir_q;
    status = '0;
    status[STAT_INT_BIT] = int_q;
  end

  // R3
  drdy_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd || release_rd) && !drdy_evt |=> !drdy_q);
  // R4
  wake_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wake_q && !release_rd |=> wake_q);
  // R4
  dir_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !release_rd && !wake_evt |=> $stable(dir_q));
  // R5
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (data_rd || release_rd) && !drdy_evt && !wake_evt |=> !int_q);
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen #(
  parameter int PULSE_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active
);
  localparam int CNT_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(PULSE_CYCLES);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (trig)         cnt_q <= LOAD;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign active = (cnt_q != '0);

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    trig |=> active);
  // R8
  pulse_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !trig && !active |=> !active);
endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive (
  input  logic clk,
  input  logic rst,
  input  logic pin_en,
  input  logic pin_pol,
  input  logic level,
  output logic pin_q
);
  always_ff @(posedge clk) begin
    if (rst)         pin_q <= ~pin_pol;
    else if (pin_en) pin_q <= pin_pol ? level : ~level;
    else             pin_q <= ~pin_pol;
  end

  // R6
  pin_off_chk: assert property (@(posedge clk) disable iff (rst)
    !pin_en |=> pin_q == !$past(pin_pol));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int PULSE_CYCLES = 4000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sample_stb,
  input  logic       wake_stb,
  input  logic [5:0] wake_dir,
  input  logic       data_rd,
  input  logic       release_rd,
  input  logic       drdy_en,
  input  logic       pin_en,
  input  logic       pin_pol,
  input  logic       pin_pulse,
  output logic [7:0] src1,
  output logic [7:0] src2,
  output logic [7:0] status,
  output logic       irq_pin
);
  import irq_latch_pkg::*;

  logic drdy_evt, wake_evt;
  logic hold_q, arm_q;
  logic pulse_trig, pulse_active, level;

  assign drdy_evt = sample_stb && drdy_en;
  assign wake_evt = wake_stb;

  irq_src_latch u_src (
    .clk(clk), .rst(rst), .drdy_evt(drdy_evt), .wake_evt(wake_evt),
    .wake_dir(wake_dir), .data_rd(data_rd), .release_rd(release_rd),
    .src1(src1), .src2(src2), .status(status)
  );

  // latched-mode hold: only a release read drops it
  always_ff @(posedge clk) begin
    if (rst)                        hold_q <= 1'b0;
    else if (drdy_evt || wake_evt)  hold_q <= 1'b1;
    else if (release_rd)            hold_q <= 1'b0;
  end

  // wake one-shot arming for pulse mode
  always_ff @(posedge clk) begin
    if (rst)                         arm_q <= 1'b1;
    else if (wake_evt && pin_pulse)  arm_q <= 1'b0;
    else if (release_rd)             arm_q <= 1'b1;
  end

  assign pulse_trig = pin_pulse && (drdy_evt || (wake_evt && arm_q));

  irq_pulse_gen #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .trig(pulse_trig), .active(pulse_active)
  );

  assign level = pin_pulse ? pulse_active : hold_q;

  irq_pin_drive u_pin (
    .clk(clk), .rst(rst), .pin_en(pin_en), .pin_pol(pin_pol),
    .level(level), .pin_q(irq_pin)
  );

  // R9
  disarm_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !arm_q && !release_rd |=> !arm_q);
  // R7
  hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
    hold_q && !release_rd |=> hold_q);
endmodule

// File: tb/irq_latch_ctrl_test.sv
module irq_latch_ctrl_test;
  localparam int PW = 6;
  logic clk = 0;
  logic rst = 1;
  logic sample_stb = 0, wake_stb = 0, data_rd = 0, release_rd = 0;
  logic [5:0] wake_dir = '0;
  logic drdy_en = 0, pin_en = 0, pin_pol = 1, pin_pulse = 0;
  logic [7:0] src1, src2, status;
  logic irq_pin;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  irq_latch_ctrl #(.PULSE_CYCLES(PW)) uut (
    .clk(clk), .rst(rst), .sample_stb(sample_stb), .wake_stb(wake_stb),
    .wake_dir(wake_dir), .data_rd(data_rd), .release_rd(release_rd),
    .drdy_en(drdy_en), .pin_en(pin_en), .pin_pol(pin_pol), .pin_pulse(pin_pulse),
    .src1(src1), .src2(src2), .status(status), .irq_pin(irq_pin)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(logic s, logic w, logic [5:0] d, logic dr, logic rl);
    sample_stb = s; wake_stb = w; wake_dir = d; data_rd = dr; release_rd = rl;
    cyc();
    sample_stb = 0; wake_stb = 0; wake_dir = '0; data_rd = 0; release_rd = 0;
  endtask

  // count active cycles of the pin over a window, starting after the event edge
  task automatic count_active(output int n);
    n = 0;
    for (int i = 0; i < 3 * PW; i++) begin
      cyc();
      if (irq_pin === pin_pol) n++;
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    cyc(); cyc();
    // R1 reset state
    chk("R1 src1", src1, 8'h00);
    chk("R1 src2", src2, 8'h00);
    chk("R1 status", status, 8'h00);
    chk("R1 pin", {7'b0, irq_pin}, 8'h00);
    rst = 0;
    cyc();

    // R2 sample without enable
    strobe(1, 0, 0, 0, 0);
    chk("R2 disabled", src1, 8'h00);
    drdy_en = 1;
    strobe(1, 0, 0, 0, 0);
    chk("R2 set", src1, 8'h10);
    chk("R5 set", status, 8'h10);
    // R3 data read clears
    strobe(0, 0, 0, 1, 0);
    chk("R3 data clear", src1, 8'h00);
    chk("R5 data clear", status, 8'h00);
    // R3 tie: sample wins
    strobe(1, 0, 0, 0, 0);
    strobe(1, 0, 0, 1, 0);
    chk("R3 tie", src1, 8'h10);
    chk("R5 tie", status, 8'h10);
    strobe(0, 0, 0, 0, 1);
    chk("R3 release clear", src1, 8'h00);

    // R4 sweep all direction patterns
    for (int d = 0; d < 64; d++) begin
      strobe(0, 1, d[5:0], 0, 0);
      chk("R4 src2", src2, 8'(d));
      chk("R4 src1", src1, 8'h02);
      chk("R5 wake", status, 8'h10);
      strobe(0, 0, 0, 1, 0);
      chk("R4 survives data read", src2, 8'(d));
      chk("R5 data clears status", status, 8'h00);
      strobe(0, 0, 0, 0, 1);
      chk("R4 release", src2, 8'h00);
    end
    // R4 accumulation and tie with release
    strobe(0, 1, 6'b100000, 0, 0);
    strobe(0, 1, 6'b000001, 0, 0);
    chk("R4 accumulate", src2, 8'h21);
    strobe(0, 1, 6'b000100, 0, 1);
    chk("R4 release tie", src2, 8'h04);
    strobe(0, 0, 0, 0, 1);

    // R6/R7 latched mode over enable and polarity
    pin_pulse = 0;
    for (int c = 0; c < 4; c++) begin
      pin_en = c[1]; pin_pol = c[0];
      cyc(); cyc();
      chk("R6 idle", {7'b0, irq_pin}, {7'b0, ~pin_pol});
      strobe(1, 0, 0, 0, 0);
      cyc();
      chk("R7 active", {7'b0, irq_pin}, {7'b0, pin_en ? pin_pol : ~pin_pol});
      strobe(0, 0, 0, 1, 0);
      cyc();
      chk("R7 data read keeps", {7'b0, irq_pin}, {7'b0, pin_en ? pin_pol : ~pin_pol});
      strobe(0, 0, 0, 0, 1);
      chk("R7 still on at release edge", {7'b0, irq_pin}, {7'b0, pin_en ? pin_pol : ~pin_pol});
      cyc();
      chk("R7 released", {7'b0, irq_pin}, {7'b0, ~pin_pol});
    end

    // R8 pulse width, both polarities
    pin_pulse = 1; pin_en = 1;
    for (int p = 0; p < 2; p++) begin
      pin_pol = p[0];
      cyc(); cyc();
      strobe(1, 0, 0, 0, 0);
      count_active(n);
      chk("R8 width", 8'(n), 8'(PW));
      strobe(0, 0, 0, 0, 1);
    end
    // R8 restart mid-pulse: 3 cycles then full width again
    pin_pol = 1;
    strobe(1, 0, 0, 0, 0);
    cyc(); cyc();
    strobe(1, 0, 0, 0, 0);
    count_active(n);
    chk("R8 restart", 8'(n + 3), 8'(PW + 3));
    strobe(0, 0, 0, 0, 1);

    // R9 wake one-shot
    strobe(0, 1, 6'h01, 0, 0);
    count_active(n);
    chk("R9 first wake", 8'(n), 8'(PW));
    strobe(0, 1, 6'h02, 0, 0);
    count_active(n);
    chk("R9 disarmed", 8'(n), 8'd0);
    strobe(1, 0, 0, 0, 0);
    count_active(n);
    chk("R9 drdy while disarmed", 8'(n), 8'(PW));
    strobe(0, 0, 0, 0, 1);
    strobe(0, 1, 6'h04, 0, 0);
    count_active(n);
    chk("R9 rearmed", 8'(n), 8'(PW));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule